// File: doc/BRIEF.md
# Sequencer Special Register File

This block is the byte-wide register space that a small microsequencer reads and writes during every instruction. It holds an 8-bit accumulator, a 16-bit source index, a 16-bit destination index and a small scratch memory. It also decodes a set of special addresses:

- an indirect read port that fetches from scratch at the source index and then advances that index;
- an indirect write port that stores at the destination index and then advances that index;
- a constant 0xFF source and a constant 0x00 source;
- a discard sink for writes;
- a conversion register that turns a 3-bit number into a one-hot byte.

Branch instructions that carry an immediate operand load it into the source index through a separate side port.

There is one read port and one write port, each 8 bits wide. Both accept a request in every cycle; neither applies back-pressure. A read is requested with `rd_en`, and its byte is returned one cycle later with `rd_vld` raised for exactly one cycle. A write takes effect at the clock edge on which `wr_en` is sampled. The destination index is free to be used as a plain scratch register as well.

Address map:

| Address | Read | Write |
|---|---|---|
| 0x00–0x3F | scratch byte | scratch byte |
| 0x40 | accumulator | accumulator |
| 0x42 | source index, low byte | source index, low byte |
| 0x43 | source index, high byte | source index, high byte |
| 0x44 | destination index, low byte | destination index, low byte |
| 0x45 | destination index, high byte | destination index, high byte |
| 0x48 | 0xFF | ignored |
| 0x4A | 0x00 | discarded |
| 0x4C | indirect read port | ignored |
| 0x4D | 0x00 | indirect write port |
| 0x50 | conversion register (one-hot) | conversion register (index) |
| any other | 0x00 | ignored |

Top module: `seq_spreg_file`

## Requirements
- R1: After reset the accumulator, both index registers and the conversion register hold zero, so a read of the conversion register returns 0x01. `rd_vld` is low.
- R2: Each read sampled with `rd_en` high returns its byte on `rd_data` one cycle later, with `rd_vld` high for that one cycle. `rd_vld` is low in every cycle that follows a cycle without `rd_en`.
- R3: Addresses 0x00–0x3F are scratch bytes and 0x40 is the accumulator; each is readable and writable. The source index low and high bytes sit at 0x42 and 0x43, and the destination index low and high bytes at 0x44 and 0x45.
- R4: A read of 0x4C returns scratch[source index mod 64] and then increments the source index by 1.
- R5: A write to 0x4D stores the data at scratch[destination index mod 64] and then increments the destination index by 1.
- R6: Index increments wrap modulo 2^16: 0xFFFF advances to 0x0000.
- R7: A read of 0x48 returns 0xFF, and a read of 0x4A returns 0x00.
- R8: Writes to 0x4A, 0x48 and 0x4C change no state. The accumulator, both indices and the scratch bytes keep their values.
- R9: A write to 0x50 keeps bits [6:4] as an index n and ignores bit 7 and bits [3:0]. Reads of 0x50 then return a byte with only bit n set: 0x60 gives 0x40, 0xE0 gives 0x40, 0x70 gives 0x80 and 0x0F gives 0x01.
- R10: With `imm_valid` high, `imm_data` is loaded into the source index low byte and the high byte is kept. The load cancels any source increment in that cycle, and a bus write to 0x42 in the same cycle takes precedence over the load.
- R11: A bus write to either byte of the source index in the same cycle as an indirect read has priority. The written byte takes the data, the other byte keeps its old value, and no increment occurs.
- R12: Reads of unmapped addresses, and of the write-only port 0x4D, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read result, registered |
| rd_vld | output | 1 | Read result valid, one cycle after `rd_en` |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| imm_valid | input | 1 | Load the immediate operand into the source index low byte |
| imm_data | input | 8 | Immediate operand |

## Verification
Every read result is due exactly one cycle after the edge that samples `rd_en`. The index increment or write caused by that access becomes visible to a read issued in the next cycle. Stimulus is applied on the falling edge. The driver pushes each expected byte into a queue at the moment it issues the read. A monitor samples 2 ns after each rising edge, pops one entry whenever `rd_vld` is high, and flags any `rd_vld` that arrives with the queue empty. Back-to-back indirect reads therefore check both the one-cycle latency and the increment from the previous cycle.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int BUS_W = 8;
  localparam logic [7:0] A_ACC     = 8'h40;
  localparam logic [7:0] A_SRC_LO  = 8'h42;
  localparam logic [7:0] A_SRC_HI  = 8'h43;
  localparam logic [7:0] A_DST_LO  = 8'h44;
  localparam logic [7:0] A_DST_HI  = 8'h45;
  localparam logic [7:0] A_ONES    = 8'h48;
  localparam logic [7:0] A_ZERO    = 8'h4A;
  localparam logic [7:0] A_SRC_IND = 8'h4C;
  localparam logic [7:0] A_DST_IND = 8'h4D;
  localparam logic [7:0] A_ONEHOT  = 8'h50;
endpackage

// File: rtl/ssr_index.sv
module ssr_index #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W/8-1:0]    wr_sel,
  input  logic [7:0]        wdata,
  input  logic              ld_lo,
  input  logic [7:0]        ld_data,
  input  logic              inc,
  output logic [W-1:0]      val
);
  localparam int NB = W / 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
    end else if (|wr_sel) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_sel[b]) val[b*8 +: 8] <= wdata;
      end
    end else if (ld_lo) begin
      val[7:0] <= ld_data;
    end else if (inc) begin
      val <= val + W'(1);
    end
  end

  // R6: a lone increment advances by one, wrapping modulo 2^W
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !(|wr_sel) && !ld_lo) |=> (val == $past(val) + W'(1)));

  // R11: a bus write to the low byte beats the increment
  assert_wr_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && wr_sel[0]) |=> (val[7:0] == $past(wdata)));

  // R10: immediate load lands in the low byte and keeps the upper bytes
  assert_imm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo && !(|wr_sel)) |=> (val[7:0] == $past(ld_data) && val[W-1:8] == $past(val[W-1:8])));
endmodule

// File: rtl/ssr_scratch.sv
module ssr_scratch #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ssr_onehot.sv
module ssr_onehot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] code_in,
  output logic [7:0] code_out
);
  logic [2:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  sel_q <= '0;
    else if (we) sel_q <= code_in;
  end

  always_comb begin
    code_out = '0;
    code_out[sel_q] = 1'b1;
  end

  // R9: output always carries exactly one set bit
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(code_out) == 1);
endmodule

// File: rtl/seq_spreg_file.sv
module seq_spreg_file #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       rd_vld,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       imm_valid,
  input  logic [7:0] imm_data
);
  import ssr_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam logic [8:0] DEPTH9 = 9'(DEPTH);

  logic             wr_scr, rd_scr;
  logic             src_inc, dst_inc;
  logic [1:0]       src_sel, dst_sel;
  logic [IDX_W-1:0] src_val, dst_val;
  logic [7:0]       acc_q, scr_rdata, oh_val, rd_next;
  logic             scr_we;
  logic [AW-1:0]    scr_waddr, scr_raddr;

  assign wr_scr  = wr_en && ({1'b0, wr_addr} < DEPTH9);
  assign rd_scr  = {1'b0, rd_addr} < DEPTH9;
  assign src_inc = rd_en && (rd_addr == A_SRC_IND);
  assign dst_inc = wr_en && (wr_addr == A_DST_IND);
  assign src_sel = {wr_en && (wr_addr == A_SRC_HI), wr_en && (wr_addr == A_SRC_LO)};
  assign dst_sel = {wr_en && (wr_addr == A_DST_HI), wr_en && (wr_addr == A_DST_LO)};

  ssr_index #(.W(IDX_W)) u_src (
    .clk(clk), .rst_n(rst_n), .wr_sel(src_sel), .wdata(wr_data),
    .ld_lo(imm_valid), .ld_data(imm_data), .inc(src_inc), .val(src_val));

  ssr_index #(.W(IDX_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .wr_sel(dst_sel), .wdata(wr_data),
    .ld_lo(1'b0), .ld_data(8'h00), .inc(dst_inc), .val(dst_val));

  assign scr_we    = wr_scr || dst_inc;
  assign scr_waddr = dst_inc ? dst_val[AW-1:0] : wr_addr[AW-1:0];
  assign scr_raddr = src_inc ? src_val[AW-1:0] : rd_addr[AW-1:0];

  ssr_scratch #(.DEPTH(DEPTH)) u_scr (
    .clk(clk), .we(scr_we), .waddr(scr_waddr), .wdata(wr_data),
    .raddr(scr_raddr), .rdata(scr_rdata));

  ssr_onehot u_oh (
    .clk(clk), .rst_n(rst_n), .we(wr_en && (wr_addr == A_ONEHOT)),
    .code_in(wr_data[6:4]), .code_out(oh_val));

  always_ff @(posedge clk) begin
    if (!rst_n)                           acc_q <= '0;
    else if (wr_en && (wr_addr == A_ACC)) acc_q <= wr_data;
  end

  always_comb begin
    rd_next = 8'h00;
    if (rd_scr) begin
      rd_next = scr_rdata;
    end else begin
      case (rd_addr)
        A_ACC:     rd_next = acc_q;
        A_SRC_LO:  rd_next = src_val[7:0];
        A_SRC_HI:  rd_next = src_val[15:8];
        A_DST_LO:  rd_next = dst_val[7:0];
        A_DST_HI:  rd_next = dst_val[15:8];
        A_ONES:    rd_next = 8'hFF;
        A_SRC_IND: rd_next = scr_rdata;
        A_ONEHOT:  rd_next = oh_val;
        default:   rd_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R2: a request yields a valid result in the next cycle, and none without one
  assert_rdvld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);
  assert_norvld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld);

  // R7: constant sources
  assert_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_ONES) |=> (rd_data == 8'hFF));
  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_ZERO) |=> (rd_data == 8'h00));

  // R8: a write to the sink leaves the registers untouched
  assert_sink_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ZERO && !imm_valid && !src_inc)
      |=> ($stable(acc_q) && $stable(src_val) && $stable(dst_val)));
endmodule

// File: tb/seq_spreg_file_tb_top.sv
`timescale 1ns/1ps
module seq_spreg_file_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_en, wr_en, imm_valid;
  logic [7:0] rd_addr, wr_addr, wr_data, imm_data;
  logic [7:0] rd_data;
  logic       rd_vld;

  always #10 clk = ~clk;

  seq_spreg_file dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_vld(rd_vld), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .imm_valid(imm_valid), .imm_data(imm_data));

  logic [7:0] exp_q [$];
  string      tag_q [$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, ex);
    end
  endtask

  task automatic step(input bit re, input logic [7:0] ra, input bit we, input logic [7:0] wa,
                      input logic [7:0] wd, input bit iv, input logic [7:0] id,
                      input logic [7:0] ex, input string tag);
    @(negedge clk);
    rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
    imm_valid = iv; imm_data = id;
    if (re) begin
      exp_q.push_back(ex);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b0, 8'h00, 1'b1, a, d, 1'b0, 8'h00, 8'h00, "");
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] ex, input string tag);
    step(1'b1, a, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, ex, tag);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, "");
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #2;
    if (rst_n === 1'b1 && rd_vld === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 spurious valid", rd_data, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      check(1'b0, "watchdog", 8'h00, 8'h00);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rd_en = 0; wr_en = 0; imm_valid = 0;
    rd_addr = 0; wr_addr = 0; wr_data = 0; imm_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(rd_vld === 1'b0, "R1 rd_vld after reset", {7'd0, rd_vld}, 8'h00);

    // R1 reset state
    rd(8'h40, 8'h00, "R1 acc");
    rd(8'h42, 8'h00, "R1 src lo");
    rd(8'h45, 8'h00, "R1 dst hi");
    rd(8'h50, 8'h01, "R1 onehot");

    // R3 direct registers
    wr(8'h40, 8'hA5);
    rd(8'h40, 8'hA5, "R3 acc");
    wr(8'h05, 8'h11); wr(8'h06, 8'h22); wr(8'h07, 8'h33);
    rd(8'h06, 8'h22, "R3 scratch");
    wr(8'h44, 8'h9C);
    rd(8'h44, 8'h9C, "R3 dst lo scratch use");

    // R4 indirect read, back to back
    wr(8'h42, 8'h05); wr(8'h43, 8'h00);
    rd(8'h4C, 8'h11, "R4 ind 0");
    rd(8'h4C, 8'h22, "R4 ind 1");
    rd(8'h4C, 8'h33, "R4 ind 2");
    rd(8'h42, 8'h08, "R4 src after 3");
    wr(8'h42, 8'h45); wr(8'h43, 8'h01);
    rd(8'h4C, 8'h11, "R4 ind mod depth");

    // R5 indirect write
    wr(8'h44, 8'h10); wr(8'h45, 8'h00);
    wr(8'h4D, 8'h77); wr(8'h4D, 8'h88);
    rd(8'h10, 8'h77, "R5 stored 0");
    rd(8'h11, 8'h88, "R5 stored 1");
    rd(8'h44, 8'h12, "R5 dst after 2");

    // R6 wrap
    wr(8'h3F, 8'h5C);
    wr(8'h42, 8'hFF); wr(8'h43, 8'hFF);
    rd(8'h4C, 8'h5C, "R6 src ind at ffff");
    rd(8'h42, 8'h00, "R6 src lo wrap");
    rd(8'h43, 8'h00, "R6 src hi wrap");
    wr(8'h44, 8'hFF); wr(8'h45, 8'hFF);
    wr(8'h4D, 8'h9E);
    rd(8'h44, 8'h00, "R6 dst lo wrap");
    rd(8'h45, 8'h00, "R6 dst hi wrap");
    rd(8'h3F, 8'h9E, "R6 dst ind at ffff");

    // R7 constants
    rd(8'h48, 8'hFF, "R7 ones");
    rd(8'h4A, 8'h00, "R7 zeros");

    // R8 ignored writes
    wr(8'h4A, 8'h12); wr(8'h48, 8'h34); wr(8'h4C, 8'h56);
    rd(8'h40, 8'hA5, "R8 acc kept");
    rd(8'h42, 8'h00, "R8 src kept");
    rd(8'h44, 8'h00, "R8 dst kept");
    rd(8'h3F, 8'h9E, "R8 scratch kept");
    rd(8'h4A, 8'h00, "R8 sink reads zero");

    // R9 conversion register
    wr(8'h50, 8'h60); rd(8'h50, 8'h40, "R9 0x60");
    wr(8'h50, 8'hE0); rd(8'h50, 8'h40, "R9 bit7 ignored");
    wr(8'h50, 8'h70); rd(8'h50, 8'h80, "R9 0x70");
    rd(8'h50, 8'h80, "R9 repeat read");
    wr(8'h50, 8'h0F); rd(8'h50, 8'h01, "R9 low nibble ignored");

    // R10 immediate load
    wr(8'h43, 8'h12); wr(8'h42, 8'h00);
    step(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'h34, 8'h00, "");
    rd(8'h42, 8'h34, "R10 imm lo");
    rd(8'h43, 8'h12, "R10 hi kept");
    wr(8'h42, 8'h05); wr(8'h43, 8'h00);
    step(1'b1, 8'h4C, 1'b0, 8'h00, 8'h00, 1'b1, 8'h20, 8'h11, "R10 ind read with imm");
    rd(8'h42, 8'h20, "R10 imm cancels inc");
    step(1'b0, 8'h00, 1'b1, 8'h42, 8'h07, 1'b1, 8'h09, 8'h00, "");
    rd(8'h42, 8'h07, "R10 bus write beats imm");

    // R11 direct write beats increment
    wr(8'h42, 8'h05); wr(8'h43, 8'h00);
    step(1'b1, 8'h4C, 1'b1, 8'h43, 8'h03, 1'b0, 8'h00, 8'h11, "R11 ind read data");
    rd(8'h42, 8'h05, "R11 lo not incremented");
    rd(8'h43, 8'h03, "R11 hi written");
    step(1'b1, 8'h4C, 1'b1, 8'h42, 8'h06, 1'b0, 8'h00, 8'h11, "R11 ind read data lo");
    rd(8'h42, 8'h06, "R11 lo written");

    // R12 unmapped and write-only
    rd(8'h60, 8'h00, "R12 unmapped 60");
    rd(8'h4D, 8'h00, "R12 write-only port");
    rd(8'hFF, 8'h00, "R12 unmapped ff");

    idle(); idle(); idle();
    @(negedge clk);
    check(exp_q.size() == 0, "R2 all results returned", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule